// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block turns reads on a memory-mapped bus window into read transactions on a single-line serial flash. A bus master presents a byte offset into the window together with a valid flag. The engine first checks a small direct-mapped read buffer. On a hit it returns the 32-bit word one cycle later. On a miss it opens one chip-select frame, sends the phases that software has configured, and writes the returned bytes into the buffer. It then looks the request up again and answers from the buffer.

Three word-addressed control registers set up the transaction. The first holds the opcode. The second holds the enables for the opcode, address and dummy phases and the dummy length. The third holds the burst setup and a self-clearing invalidate bit. The flash address always comes from the bus offset.

Every miss runs a complete flash transaction, even when the master discards the returned word. A read whose data is thrown away can therefore be used to touch the flash.

Top module: `flash_read_engine`

## Requirements
- R1: After reset, spiCsN is high, spiSclk is low, memReady is low, and all three control registers read as zero.
- R2: On a miss, when bit 0 of register 1 is set, the frame begins with the 8-bit opcode held in bits 23:16 of register 0, most significant bit first. When that bit is clear, no opcode is sent.
- R3: When the 3-bit field at bits 6:4 of register 1 equals 7, the opcode is followed by the fetch start address as 24 bits, most significant bit first. Any other value leaves out the address phase.
- R4: When bit 8 of register 1 is set, a dummy phase follows the address phase. It lasts (bits 15:12 of register 1) + 1 serial clocks, with spiMosi held low.
- R5: When burst mode is on (bit 0 of register 2 = 1), a miss fetches (bits 12:8 of register 2) + 1 consecutive 8-byte units in one frame. The first unit starts at the request offset with bits 2:0 cleared. All of these units then hit.
- R6: When burst mode is off, a miss fetches exactly 4 bytes, starting at the request offset with bits 1:0 cleared. The other word of the same 8-byte unit stays uncached.
- R7: Within a returned word, the byte from the lowest flash address sits in bits 7:0 and the byte from the highest address sits in bits 31:24.
- R8: A read that hits returns memReady for exactly one cycle, one cycle after the request is accepted, and produces no serial activity.
- R9: On a miss, memReady stays low while spiCsN is low. Data is returned only after the frame has ended.
- R10: Writing 1 to bit 1 of register 2 invalidates every buffered word, so the next read fetches from flash again. The bit reads back as 0.
- R11: The serial clock idles low, spiMosi changes only while spiSclk is low, and spiMiso is sampled on the rising edge of spiSclk.
- R12: Register 0 reads back only bits 23:16. Register 1 reads back bits 0, 6:4, 8 and 15:12. Register 2 reads back bits 0 and 12:8. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memValid | input | 1 | Read request, held until memReady |
| memAddr | input | 24 | Byte offset into the flash window, held with memValid |
| memReady | output | 1 | One-cycle pulse, memRdata is valid |
| memRdata | output | 32 | Returned word |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSclk | output | 1 | Serial clock, half the core rate |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The hardest state to reach from the ports is a buffered line that really is valid, followed by an invalidate that wipes it. Only the frame count shows whether a read was served from the buffer. The bench therefore models the flash itself: it decodes the opcode and address from spiMosi and counts frames and serial clocks. It first shows that a read hits, with no new frame and a one-cycle answer. It then writes the invalidate bit and shows that the same read opens a new frame.

The missing-phase cases are reached by reprogramming the phase enables between reads. In each case the exact number of serial clocks per frame is checked.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 12;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  typedef struct packed {
    logic       cmdEn;
    logic [7:0] opcode;
    logic       addrEn;
    logic       dummyEn;
    logic [3:0] dummyCnt;
    logic       burstEn;
    logic [4:0] burstLen;
  } cfg_t;

  typedef struct packed {
    logic startFill;
    logic loadCmd;
    logic loadAddr;
    logic loadZero;
    logic shiftTx;
    logic sampleRx;
    logic commitByte;
    logic captureRead;
  } strobe_t;

endpackage

// File: rtl/flash_rd_datapath.sv
module flash_rd_datapath
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LINES  = 32,
  parameter int REG_AW = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWdata,
  output logic [WORD_W-1:0]   regRdata,
  input  logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memRdata,
  output cfg_t                cfg,
  output logic                hit,
  input  strobe_t             strb,
  input  logic                miso,
  output logic                mosi
);

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = 3;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  // configuration registers
  logic [7:0] opcodeQ;
  logic       cmdEnQ;
  logic [2:0] addrFieldQ;
  logic       dummyEnQ;
  logic [3:0] dummyCntQ;
  logic       burstEnQ;
  logic [4:0] burstLenQ;
  logic       flushWr;

  assign flushWr = regWe && (regAddr == REG_AW'(2)) && regWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ    <= '0;
      cmdEnQ     <= 1'b0;
      addrFieldQ <= '0;
      dummyEnQ   <= 1'b0;
      dummyCntQ  <= '0;
      burstEnQ   <= 1'b0;
      burstLenQ  <= '0;
    end else if (regWe) begin
      case (regAddr)
        REG_AW'(0): opcodeQ <= regWdata[23:16];
        REG_AW'(1): begin
          cmdEnQ     <= regWdata[0];
          addrFieldQ <= regWdata[6:4];
          dummyEnQ   <= regWdata[8];
          dummyCntQ  <= regWdata[15:12];
        end
        REG_AW'(2): begin
          burstEnQ  <= regWdata[0];
          burstLenQ <= regWdata[12:8];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      REG_AW'(0): regRdata = {8'b0, opcodeQ, 16'b0};
      REG_AW'(1): regRdata = {16'b0, dummyCntQ, 3'b0, dummyEnQ, 1'b0, addrFieldQ, 3'b0, cmdEnQ};
      REG_AW'(2): regRdata = {19'b0, burstLenQ, 7'b0, burstEnQ};
      default:    regRdata = '0;
    endcase
  end

  assign cfg = '{cmdEn: cmdEnQ, opcode: opcodeQ, addrEn: (addrFieldQ == 3'd7),
                 dummyEn: dummyEnQ, dummyCnt: dummyCntQ,
                 burstEn: burstEnQ, burstLen: burstLenQ};

  // fetch start address derived from the pending request
  logic [ADDR_W-1:0] missBase;
  assign missBase = burstEnQ ? {memAddr[ADDR_W-1:3], 3'b000}
                             : {memAddr[ADDR_W-1:2], 2'b00};

  // serial shift registers
  logic [ADDR_W-1:0] txShift;
  logic [6:0]        rxShift;
  logic [7:0]        rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.loadCmd)       txShift <= {opcodeQ, {(ADDR_W-8){1'b0}}};
      else if (strb.loadAddr) txShift <= missBase;
      else if (strb.loadZero) txShift <= '0;
      else if (strb.shiftTx)  txShift <= {txShift[ADDR_W-2:0], 1'b0};
      if (strb.sampleRx)      rxShift <= {rxShift[5:0], miso};
    end
  end

  assign mosi   = txShift[ADDR_W-1];
  assign rxByte = {rxShift, miso};

  // fill pointer
  logic [ADDR_W-1:0] fillAddr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                fillAddr <= '0;
    else if (strb.startFill)  fillAddr <= missBase;
    else if (strb.commitByte) fillAddr <= fillAddr + 1'b1;
  end

  logic [IDX_W-1:0] fIdx, lIdx;
  logic [TAG_W-1:0] fTag, lTag;
  logic             fWord, lWord;
  logic [1:0]       fByte;

  assign fIdx  = fillAddr[OFF_W +: IDX_W];
  assign fTag  = fillAddr[ADDR_W-1 -: TAG_W];
  assign fWord = fillAddr[2];
  assign fByte = fillAddr[1:0];
  assign lIdx  = memAddr[OFF_W +: IDX_W];
  assign lTag  = memAddr[ADDR_W-1 -: TAG_W];
  assign lWord = memAddr[2];

  // buffer storage: tag and data per line, one valid bit per word
  logic [63:0]        lineData [LINES];
  logic [TAG_W-1:0]   lineTag  [LINES];
  logic [2*LINES-1:0] validBits;

  always_ff @(posedge clk) begin
    if (strb.commitByte) begin
      lineData[fIdx][{fillAddr[2:0], 3'b000} +: 8] <= rxByte;
      if (fByte == 2'd0) lineTag[fIdx] <= fTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (flushWr) begin
      validBits <= '0;
    end else if (strb.commitByte) begin
      if (fByte == 2'd0) begin
        if (lineTag[fIdx] != fTag) begin
          validBits[{fIdx, 1'b0}] <= 1'b0;
          validBits[{fIdx, 1'b1}] <= 1'b0;
        end else begin
          validBits[{fIdx, fWord}] <= 1'b0;
        end
      end else if (fByte == 2'd3) begin
        validBits[{fIdx, fWord}] <= 1'b1;
      end
    end
  end

  assign hit = validBits[{lIdx, lWord}] && (lineTag[lIdx] == lTag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 memRdata <= '0;
    else if (strb.captureRead) memRdata <= lWord ? lineData[lIdx][63:32] : lineData[lIdx][31:0];
  end

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushWr |=> (validBits == '0));

endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    memValid,
  input  logic    hit,
  input  cfg_t    cfg,
  output strobe_t strb,
  output logic    memReady,
  output logic    csN,
  output logic    sclk
);

  typedef enum logic [1:0] {ST_IDLE, ST_RESP, ST_XFER, ST_HOLD} state_e;

  state_e           state;
  phase_e           phase;
  logic [CNT_W-1:0] bitsLeft;
  phase_e           firstPh, nextPh, loadPh;
  logic             doLoad;

  function automatic logic [CNT_W-1:0] phaseBits(phase_e p, cfg_t c);
    case (p)
      PH_CMD:   return CNT_W'(8);
      PH_ADDR:  return CNT_W'(ADDR_W);
      PH_DUMMY: return CNT_W'(c.dummyCnt) + CNT_W'(1);
      default:  return c.burstEn ? ((CNT_W'(c.burstLen) + CNT_W'(1)) << 6) : CNT_W'(32);
    endcase
  endfunction

  always_comb begin
    if (cfg.cmdEn)        firstPh = PH_CMD;
    else if (cfg.addrEn)  firstPh = PH_ADDR;
    else if (cfg.dummyEn) firstPh = PH_DUMMY;
    else                  firstPh = PH_DATA;
    case (phase)
      PH_CMD:   nextPh = cfg.addrEn ? PH_ADDR : (cfg.dummyEn ? PH_DUMMY : PH_DATA);
      PH_ADDR:  nextPh = cfg.dummyEn ? PH_DUMMY : PH_DATA;
      default:  nextPh = PH_DATA;
    endcase
  end

  always_comb begin
    strb   = '0;
    doLoad = 1'b0;
    loadPh = PH_DATA;
    case (state)
      ST_IDLE: if (memValid) begin
        if (hit) strb.captureRead = 1'b1;
        else begin
          strb.startFill = 1'b1;
          doLoad = 1'b1;
          loadPh = firstPh;
        end
      end
      ST_XFER: begin
        if (!sclk) begin
          strb.sampleRx   = (phase == PH_DATA);
          strb.commitByte = (phase == PH_DATA) && (bitsLeft[2:0] == 3'd1);
        end else if (bitsLeft == CNT_W'(1)) begin
          if (phase != PH_DATA) begin
            doLoad = 1'b1;
            loadPh = nextPh;
          end
        end else begin
          strb.shiftTx = 1'b1;
        end
      end
      default: ;
    endcase
    if (doLoad) begin
      case (loadPh)
        PH_CMD:  strb.loadCmd  = 1'b1;
        PH_ADDR: strb.loadAddr = 1'b1;
        default: strb.loadZero = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_CMD;
      bitsLeft <= '0;
      memReady <= 1'b0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
    end else begin
      memReady <= 1'b0;
      case (state)
        ST_IDLE: if (memValid) begin
          if (hit) begin
            memReady <= 1'b1;
            state    <= ST_RESP;
          end else begin
            csN      <= 1'b0;
            phase    <= firstPh;
            bitsLeft <= phaseBits(firstPh, cfg);
            state    <= ST_XFER;
          end
        end
        ST_RESP: state <= ST_IDLE;
        ST_XFER: begin
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bitsLeft == CNT_W'(1)) begin
              if (phase == PH_DATA) state <= ST_HOLD;
              else begin
                phase    <= nextPh;
                bitsLeft <= phaseBits(nextPh, cfg);
              end
            end else begin
              bitsLeft <= bitsLeft - CNT_W'(1);
            end
          end
        end
        default: begin
          csN   <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // R11
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReady |=> !memReady);

endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LINES  = 32,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              memReady,
  output logic [31:0]       memRdata,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);

  cfg_t    cfg;
  strobe_t strb;
  logic    hit;

  flash_rd_datapath #(.ADDR_W(ADDR_W), .LINES(LINES), .REG_AW(REG_AW)) i_datapath (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .memAddr(memAddr), .memRdata(memRdata),
    .cfg(cfg), .hit(hit), .strb(strb),
    .miso(spiMiso), .mosi(spiMosi)
  );

  flash_rd_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .memValid(memValid), .hit(hit), .cfg(cfg), .strb(strb),
    .memReady(memReady), .csN(spiCsN), .sclk(spiSclk)
  );

  // R11
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && spiSclk) |-> $stable(spiMosi));

  // R9
  no_ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> !memReady);

endmodule

// File: tb/test_flash_read_engine.sv
module test_flash_read_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memValid = 1'b0;
  logic [23:0] memAddr = '0;
  logic        memReady;
  logic [31:0] memRdata;
  logic        spiCsN, spiSclk, spiMosi;
  logic        spiMiso;

  always #10 clk = ~clk;

  flash_read_engine i_flash_read_engine (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .memValid(memValid), .memAddr(memAddr), .memReady(memReady), .memRdata(memRdata),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  function automatic logic [31:0] expWord(logic [23:0] b);
    return {pat(b + 24'd3), pat(b + 24'd2), pat(b + 24'd1), pat(b)};
  endfunction

  // flash model
  int          cmdBits = 0, addrBits = 0, dumBits = 0, hdrBits = 0;
  bit          addrOn = 0;
  int          bitCnt = 0;
  int          frames = 0;
  logic [63:0] cap = '0;
  logic [7:0]  mOp = '0;
  logic [23:0] mAddr = '0;
  bit          dumHigh = 0, mosiErr = 0, readyErr = 0;
  logic        lastMosi = 1'b0;

  always @(negedge spiCsN) begin
    bitCnt = 0; mAddr = '0; cap = '0; dumHigh = 0; frames++;
  end

  always @(posedge spiSclk) if (!spiCsN) begin
    if (bitCnt >= cmdBits + addrBits && bitCnt < hdrBits && spiMosi) dumHigh = 1;
    cap = {cap[62:0], spiMosi};
    bitCnt++;
    if (cmdBits != 0 && bitCnt == cmdBits) mOp = cap[7:0];
    if (addrOn && bitCnt == cmdBits + 24) mAddr = cap[23:0];
  end

  always @* begin
    int d;
    logic [7:0] b;
    if (bitCnt < hdrBits) spiMiso = 1'b0;
    else begin
      d = bitCnt - hdrBits;
      b = pat(mAddr + 24'(d / 8));
      spiMiso = b[7 - (d % 8)];
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (!spiCsN && spiSclk && spiMosi !== lastMosi) mosiErr = 1;
      if (spiCsN && spiSclk) mosiErr = 1;
      if (!spiCsN && memReady) readyErr = 1;
    end
    lastMosi = spiMosi;
  end

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic memRead(logic [23:0] a, output logic [31:0] d, output int cyc);
    @(negedge clk); memValid = 1'b1; memAddr = a; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!memReady && cyc < 20000);
    d = memRdata;
    memValid = 1'b0;
  endtask

  task automatic configure(bit c, logic [7:0] op, logic [2:0] af, bit de, logic [3:0] dc,
                           bit be, logic [4:0] bl);
    regWrite(2'd0, {8'b0, op, 16'b0});
    regWrite(2'd1, {16'b0, dc, 3'b0, de, 1'b0, af, 3'b0, c});
    regWrite(2'd2, {19'b0, bl, 7'b0, be});
    cmdBits  = c ? 8 : 0;
    addrOn   = (af == 3'd7);
    addrBits = addrOn ? 24 : 0;
    dumBits  = de ? int'(dc) + 1 : 0;
    hdrBits  = cmdBits + addrBits + dumBits;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "csN after reset", spiCsN, 1);
    chk("R1", "sclk after reset", spiSclk, 0);
    chk("R1", "memReady after reset", memReady, 0);
    for (int i = 0; i < 3; i++) begin
      regRead(2'(i), d);
      chk("R1", "register after reset", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    regWrite(2'd0, 32'hFFFF_FFFF); regRead(2'd0, d);
    chk("R12", "reg0 mask", d, 32'h00FF_0000);
    regWrite(2'd1, 32'hFFFF_FFFF); regRead(2'd1, d);
    chk("R12", "reg1 mask", d, 32'h0000_F171);
    regWrite(2'd2, 32'hFFFF_FFFF); regRead(2'd2, d);
    chk("R10", "reg2 flush bit reads 0", d, 32'h0000_1F01);
  endtask

  task automatic t_single();
    logic [31:0] d; int cyc; int f0;
    configure(1, 8'h03, 3'd7, 0, 4'd0, 0, 5'd0);
    f0 = frames;
    memRead(24'h001236, d, cyc);
    chk("R6", "single-word frame count", frames, f0 + 1);
    chk("R2", "opcode sent", mOp, 8'h03);
    chk("R3", "address sent", mAddr, 24'h001234);
    chk("R6", "serial clocks in word fetch", bitCnt, 64);
    chk("R7", "word byte order", d, expWord(24'h001234));
    chk("R9", "miss latency exceeds frame", cyc > 64, 1);
    memRead(24'h001234, d, cyc);
    chk("R8", "hit latency", cyc, 1);
    chk("R8", "hit opens no frame", frames, f0 + 1);
    chk("R8", "hit data", d, expWord(24'h001234));
    memRead(24'h001230, d, cyc);
    chk("R6", "other word refetched", frames, f0 + 2);
    chk("R6", "other word data", d, expWord(24'h001230));
  endtask

  task automatic t_burst();
    logic [31:0] d; int cyc; int f0;
    configure(1, 8'h0B, 3'd7, 1, 4'd7, 1, 5'd1);
    f0 = frames;
    memRead(24'h00050C, d, cyc);
    chk("R5", "burst frame count", frames, f0 + 1);
    chk("R5", "burst start address", mAddr, 24'h000508);
    chk("R4", "clocks with 8 dummy cycles", bitCnt, 8 + 24 + 8 + 128);
    chk("R4", "mosi low in dummy", dumHigh, 0);
    chk("R5", "burst requested word", d, expWord(24'h00050C));
    memRead(24'h000510, d, cyc);
    chk("R5", "second unit hits", cyc, 1);
    chk("R5", "second unit data", d, expWord(24'h000510));
    memRead(24'h000514, d, cyc);
    chk("R5", "second unit upper word data", d, expWord(24'h000514));
    chk("R5", "no frame for burst hits", frames, f0 + 1);
    memRead(24'h000518, d, cyc);
    chk("R5", "beyond burst misses", frames, f0 + 2);
  endtask

  task automatic t_nophase();
    logic [31:0] d; int cyc; int f0;
    configure(0, 8'h0B, 3'd3, 1, 4'd0, 0, 5'd0);
    f0 = frames;
    memRead(24'h002000, d, cyc);
    chk("R2", "frame without opcode", frames, f0 + 1);
    chk("R3", "no address phase, clocks", bitCnt, 1 + 32);
    chk("R4", "one dummy clock data", d, expWord(24'h000000));
  endtask

  task automatic t_flush();
    logic [31:0] d; int cyc; int f0;
    configure(1, 8'h0B, 3'd7, 1, 4'd7, 1, 5'd1);
    f0 = frames;
    memRead(24'h000510, d, cyc);
    chk("R10", "line cached before flush", frames, f0);
    regWrite(2'd2, 32'h0000_0103);
    memRead(24'h000510, d, cyc);
    chk("R10", "flush forces refetch", frames, f0 + 1);
    chk("R10", "data after refetch", d, expWord(24'h000510));
    regRead(2'd2, d);
    chk("R10", "flush bit self-clears", d, 32'h0000_0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_single();
    t_burst();
    t_nophase();
    t_flush();
    chk("R11", "mosi stable while sclk high", mosiErr, 0);
    chk("R9", "no ready during frame", readyErr, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule